// File: doc/BRIEF.md
# Processor Status and Control Flag Register

This block holds the 16-bit flag word of a small processor core. After each ALU operation it takes the result and the carry information that the ALU produces. From these it updates six status flags: carry, auxiliary carry, parity, zero, sign and overflow. It works for byte-wide and word-wide operations.

Three control flags sit in the same word: single-step trap, interrupt enable and string direction. An ALU update never changes them. Software can change them only by loading the whole word. That load path is also the one used when the flag word is restored from the stack. The packed word is always visible on `flags_out`, so a push only has to read it.

The block is a register of 16 bits. In each cycle it does one of three things: hold, load or update. When a load and an update arrive in the same cycle, the load takes effect and the update is dropped. The word changes on the rising clock edge that samples the request, so the new value is visible in the following cycle.

Top module: `status_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `flags_out` reads 16'h0000 until the first load or update.
- R2: The bits of the flag word are placed as follows: carry at bit 0, parity at bit 2, auxiliary at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt at bit 9, direction at bit 10 and overflow at bit 11. Bits 1, 3, 5, 12, 13, 14 and 15 always read 0, even after a load of 16'hFFFF.
- R3: `op_sel` is encoded as 2'b01 for add, 2'b10 for subtract, and 2'b00 or 2'b11 for a logic operation. On an add or subtract update, carry copies `carry_in` and auxiliary copies `aux_carry_in`. On a logic update, carry and auxiliary are both cleared.
- R4: On an update, parity is set when bits 7:0 of `result` hold an even number of ones. This holds for both operand sizes.
- R5: On an update, zero is set when the result is zero within the operand size. For a byte operation (`word_op`=0) only bits 7:0 are compared. For a word operation (`word_op`=1) all 16 bits are compared.
- R6: On an update, sign copies `result` bit 7 for a byte operation and bit 15 for a word operation.
- R7: On an update, overflow is computed from `a_sign`, `b_sign` and the size-selected result sign. For an add, it is set when both operand signs are equal and the result sign differs from them. For a subtract, it is set when the operand signs differ and the result sign differs from `a_sign`. For a logic operation, it is cleared.
- R8: An update leaves trap, interrupt and direction at their previous values.
- R9: A load writes `load_word`, with the unused bits cleared, into the whole word. The value is visible in the cycle after the load.
- R10: When `load_en` and `upd_en` are both high in the same cycle, the loaded value is stored and the update has no effect.
- R11: When both `load_en` and `upd_en` are low, `flags_out` does not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Update the status flags from the ALU inputs |
| op_sel | input | 2 | Kind of operation: 01 add, 10 subtract, other values logic |
| word_op | input | 1 | 1 selects word size, 0 selects byte size |
| result | input | 16 | ALU result |
| a_sign | input | 1 | Sign bit of the first operand at the operand size |
| b_sign | input | 1 | Sign bit of the second operand at the operand size |
| carry_in | input | 1 | Carry or borrow out of the operand's top bit |
| aux_carry_in | input | 1 | Carry or borrow out of bit 3 |
| load_en | input | 1 | Load the whole flag word |
| load_word | input | 16 | Value for a full-word load |
| flags_out | output | 16 | Packed flag word |

## Verification
A full-word load and an ALU status update can be requested in the same cycle. This happens when an instruction restores the flags while the ALU still reports a result. The bench provokes the collision by raising `upd_en` and `load_en` on the same clock. The ALU inputs are chosen so that the update, if it were applied, would give a different word from the one loaded. The case is judged by whether `flags_out` in the next cycle equals exactly the masked load value. The bench also checks, in separate cycles, that an update alone keeps the control bits that were loaded earlier.

// File: rtl/flagreg_pkg.sv
`timescale 1ns/1ps
package flagreg_pkg;

    localparam int FLAG_W = 16;

    // Bit positions of the packed flag word
    localparam int CF_BIT = 0;
    localparam int PF_BIT = 2;
    localparam int AF_BIT = 4;
    localparam int ZF_BIT = 6;
    localparam int SF_BIT = 7;
    localparam int TF_BIT = 8;
    localparam int IF_BIT = 9;
    localparam int DF_BIT = 10;
    localparam int OF_BIT = 11;

    typedef enum logic [1:0] {
        OP_LOGIC = 2'b00,
        OP_ADD   = 2'b01,
        OP_SUB   = 2'b10,
        OP_RSVD  = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_UPDATE = 2'b01,
        ACT_LOAD   = 2'b10
    } reg_act_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } status_t;

    function automatic logic [FLAG_W-1:0] bit_at(input int pos);
        logic [FLAG_W-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    function automatic logic [FLAG_W-1:0] status_mask();
        return bit_at(CF_BIT) | bit_at(PF_BIT) | bit_at(AF_BIT) |
               bit_at(ZF_BIT) | bit_at(SF_BIT) | bit_at(OF_BIT);
    endfunction

    function automatic logic [FLAG_W-1:0] control_mask();
        return bit_at(TF_BIT) | bit_at(IF_BIT) | bit_at(DF_BIT);
    endfunction

endpackage

// File: rtl/flag_status_calc.sv
`timescale 1ns/1ps
module flag_status_calc
    import flagreg_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0] result,
    input  logic              word_op,
    input  alu_op_e           op,
    input  logic              a_sign,
    input  logic              b_sign,
    input  logic              carry_in,
    input  logic              aux_carry_in,
    output status_t           st
);
    localparam int BYTE_MSB = BYTE_W - 1;
    localparam int WORD_MSB = WORD_W - 1;

    logic res_sign;
    logic is_arith;

    always_comb begin
        res_sign = word_op ? result[WORD_MSB] : result[BYTE_MSB];
        is_arith = (op == OP_ADD) || (op == OP_SUB);

        st.cf = is_arith & carry_in;
        st.af = is_arith & aux_carry_in;
        st.pf = ~^result[BYTE_MSB:0];
        st.zf = word_op ? (result == '0) : (result[BYTE_MSB:0] == '0);
        st.sf = res_sign;

        unique case (op)
            OP_ADD:  st.of = (a_sign == b_sign) && (res_sign != a_sign);
            OP_SUB:  st.of = (a_sign != b_sign) && (res_sign != a_sign);
            default: st.of = 1'b0;
        endcase
    end

endmodule

// File: rtl/flag_pack.sv
`timescale 1ns/1ps
module flag_pack
    import flagreg_pkg::*;
(
    input  status_t           st,
    output logic [FLAG_W-1:0] status_word
);
    always_comb begin
        status_word         = '0;
        status_word[CF_BIT] = st.cf;
        status_word[PF_BIT] = st.pf;
        status_word[AF_BIT] = st.af;
        status_word[ZF_BIT] = st.zf;
        status_word[SF_BIT] = st.sf;
        status_word[OF_BIT] = st.of;
    end

endmodule

// File: rtl/flag_word_reg.sv
`timescale 1ns/1ps
module flag_word_reg
    import flagreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              load_en,
    input  logic [FLAG_W-1:0] load_word,
    input  logic [FLAG_W-1:0] status_word,
    output logic [FLAG_W-1:0] flags_q
);
    localparam logic [FLAG_W-1:0] STAT_MASK = status_mask();
    localparam logic [FLAG_W-1:0] CTL_MASK  = control_mask();
    localparam logic [FLAG_W-1:0] ALL_MASK  = STAT_MASK | CTL_MASK;

    reg_act_e          act;
    logic [FLAG_W-1:0] flags_d;

    // Action select: a load beats an update
    always_comb begin
        if (load_en)     act = ACT_LOAD;
        else if (upd_en) act = ACT_UPDATE;
        else             act = ACT_HOLD;
    end

    always_comb begin
        unique case (act)
            ACT_LOAD:   flags_d = load_word & ALL_MASK;
            ACT_UPDATE: flags_d = (flags_q & CTL_MASK) | (status_word & STAT_MASK);
            default:    flags_d = flags_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q & ~ALL_MASK) == '0);

    p_ctl_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (flags_q & CTL_MASK) == $past(flags_q & CTL_MASK));

    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> flags_q == $past(load_word & ALL_MASK));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !upd_en) |=> $stable(flags_q));

endmodule

// File: rtl/status_flag_unit.sv
`timescale 1ns/1ps
module status_flag_unit
    import flagreg_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_sel,
    input  logic              word_op,
    input  logic [WORD_W-1:0] result,
    input  logic              a_sign,
    input  logic              b_sign,
    input  logic              carry_in,
    input  logic              aux_carry_in,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] flags_out
);
    localparam int BYTE_MSB = BYTE_W - 1;
    localparam int WORD_MSB = WORD_W - 1;

    alu_op_e           op;
    status_t           st;
    logic [FLAG_W-1:0] status_word;

    assign op = alu_op_e'(op_sel);

    flag_status_calc #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) calc_i (
        .result       (result),
        .word_op      (word_op),
        .op           (op),
        .a_sign       (a_sign),
        .b_sign       (b_sign),
        .carry_in     (carry_in),
        .aux_carry_in (aux_carry_in),
        .st           (st)
    );

    flag_pack pack_i (
        .st          (st),
        .status_word (status_word)
    );

    flag_word_reg reg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_en      (upd_en),
        .load_en     (load_en),
        .load_word   (load_word),
        .status_word (status_word),
        .flags_q     (flags_out)
    );

    p_logic_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !load_en && !op_sel[0] == !op_sel[1])
        |=> !flags_out[CF_BIT] && !flags_out[AF_BIT] && !flags_out[OF_BIT]);

    p_zero_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !load_en) |=> flags_out[ZF_BIT] ==
            ($past(word_op) ? ($past(result) == '0) : ($past(result[BYTE_MSB:0]) == '0)));

    p_sign_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !load_en) |=> flags_out[SF_BIT] ==
            ($past(word_op) ? $past(result[WORD_MSB]) : $past(result[BYTE_MSB])));

endmodule

// File: tb/status_flag_unit_tb_top.sv
`timescale 1ns/1ps
module status_flag_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        word_op = 1'b0;
    logic [15:0] result = '0;
    logic        a_sign = 1'b0;
    logic        b_sign = 1'b0;
    logic        carry_in = 1'b0;
    logic        aux_carry_in = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_word = '0;
    logic [15:0] flags_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] ctl_model = '0;

    always #5 clk = ~clk;

    status_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_sel(op_sel),
        .word_op(word_op), .result(result), .a_sign(a_sign), .b_sign(b_sign),
        .carry_in(carry_in), .aux_carry_in(aux_carry_in), .load_en(load_en),
        .load_word(load_word), .flags_out(flags_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one ALU update, then compare every field with the bench model
    task automatic run_op(input logic [15:0] a, input logic [15:0] b,
                          input logic [1:0] op, input bit wsz);
        int          w;
        logic [16:0] full;
        logic [15:0] msk, res;
        logic        cy, ax, as, bs, rs, ov, arith, pe, ze;
        w     = wsz ? 16 : 8;
        msk   = wsz ? 16'hFFFF : 16'h00FF;
        a     = a & msk;
        b     = b & msk;
        arith = (op == 2'b01) || (op == 2'b10);
        if (op == 2'b01) begin
            full = {1'b0, a} + {1'b0, b};
            res  = full[15:0] & msk;
            cy   = full[w];
        end else if (op == 2'b10) begin
            res = (a - b) & msk;
            cy  = (a < b);
        end else begin
            res = a & b;
            cy  = 1'b1;
        end
        ax = arith ? (((a ^ b ^ res) >> 4) & 16'h1) != 0 : 1'b1;
        as = a[w-1];
        bs = b[w-1];
        rs = res[w-1];
        if (op == 2'b01)      ov = (as == bs) && (rs != as);
        else if (op == 2'b10) ov = (as != bs) && (rs != as);
        else                  ov = 1'b0;
        pe = ($countones(res[7:0]) % 2) == 0;
        ze = (res == 0);
        @(negedge clk);
        upd_en = 1'b1; op_sel = op; word_op = wsz;
        result = wsz ? res : (res | 16'hA500);   // upper byte is noise for byte ops
        a_sign = as; b_sign = bs; carry_in = cy; aux_carry_in = ax;
        @(negedge clk);
        upd_en = 1'b0;
        chk("R3 carry",     {15'd0, flags_out[0]},  {15'd0, arith & cy});
        chk("R3 auxiliary", {15'd0, flags_out[4]},  {15'd0, arith & ax});
        chk("R4 parity",    {15'd0, flags_out[2]},  {15'd0, pe});
        chk("R5 zero",      {15'd0, flags_out[6]},  {15'd0, ze});
        chk("R6 sign",      {15'd0, flags_out[7]},  {15'd0, rs});
        chk("R7 overflow",  {15'd0, flags_out[11]}, {15'd0, ov});
        chk("R8 control",   flags_out & 16'h0700,   ctl_model);
        chk("R2 unused",    flags_out & 16'hF02A,   16'h0000);
    endtask

    task automatic do_load(input logic [15:0] v, input bit with_upd);
        @(negedge clk);
        load_en = 1'b1; load_word = v;
        upd_en = with_upd; op_sel = 2'b01; word_op = 1'b1;
        result = 16'h8000; a_sign = 1'b0; b_sign = 1'b0;
        carry_in = 1'b1; aux_carry_in = 1'b1;
        @(negedge clk);
        load_en = 1'b0; upd_en = 1'b0;
        ctl_model = v & 16'h0700;
        chk(with_upd ? "R10 load over update" : "R9 load", flags_out, v & 16'h0FD5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset value", flags_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", flags_out, 16'h0000);

        do_load(16'hFFFF, 1'b0);
        chk("R2 mask on full load", flags_out, 16'h0FD5);
        run_op(16'h007F, 16'h0001, 2'b01, 1'b0);
        do_load(16'h0A55, 1'b1);
        do_load(16'h0000, 1'b0);

        // Idle: inputs move, enables low
        @(negedge clk);
        result = 16'h0000; carry_in = 1'b1; op_sel = 2'b10; load_word = 16'hFFFF;
        @(negedge clk);
        chk("R11 idle hold", flags_out, 16'h0000);

        // Logic op with reserved code and with code 00
        run_op(16'h00F0, 16'h000F, 2'b11, 1'b0);
        run_op(16'hFFFF, 16'h8001, 2'b00, 1'b1);

        // Byte sweeps, control bits set
        do_load(16'h0500, 1'b0);
        for (int i = 0; i < 256; i += 5)
            for (int j = 0; j < 256; j += 5) begin
                run_op(i[15:0], j[15:0], 2'b01, 1'b0);
                run_op(i[15:0], j[15:0], 2'b10, 1'b0);
            end
        // Word sweeps, other control bits
        do_load(16'h0200, 1'b0);
        for (int i = 0; i < 40; i++)
            for (int j = 0; j < 40; j++) begin
                run_op(16'(i * 16'h0683 + 16'h7FF0), 16'(j * 16'h0A19 + 16'h0008), 2'b01, 1'b1);
                run_op(16'(i * 16'h0683 + 16'h7FF0), 16'(j * 16'h0A19 + 16'h0008), 2'b10, 1'b1);
            end
        run_op(16'h8000, 16'h8000, 2'b01, 1'b1);
        run_op(16'h0000, 16'h0001, 2'b10, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule